// File: doc/BRIEF.md
# Separate-I/O Static RAM Emulator

This block is a clocked, synthesizable stand-in for an asynchronous static RAM with active-low select and write strobes, a data-in bus and a separate data-out bus. The strobes, address and input data are sampled on every rising edge of a fast system clock. A write window is the run of sampled cycles in which both strobes are low. The rise of either strobe closes the window, and the word held on the last cycle of the window is then stored.

The high-impedance state is modelled as a data/enable pair. A parameter picks what the output does during a write: it mirrors the input data (write-through), or it is released. A power-down flag reports that the part is deselected. Depth is set by the address width: 18 bits gives the full 256K-word array, and smaller defaults keep elaboration light.

Top module: `sepio_sram`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rd_en` is 0, `rd_data` is 0 and `pwr_down` is 1, whatever the strobes are doing.
- R2: A write window is the run of sampled cycles with `sel_n`=0 and `wr_n`=0. When `sel_n` or `wr_n` rises, the `wr_data` and `addr` sampled on the window's last cycle are stored.
- R3: A cycle sampled with `sel_n`=0 and `wr_n`=1 gives `rd_en`=1 one cycle later, with `rd_data` equal to the stored word at `addr`. This includes a window that closed on the cycle just before.
- R4: A cycle sampled with `sel_n`=1 gives `rd_en`=0 one cycle later. Whenever `rd_en` is 0, `rd_data` is 0.
- R5: `pwr_down` equals the `sel_n` value sampled on the previous clock edge.
- R6: With `WR_THRU`=1, a write-window cycle gives `rd_en`=1 and `rd_data` equal to that cycle's `wr_data` one cycle later.
- R7: With `WR_THRU`=0, a write-window cycle gives `rd_en`=0 one cycle later. When both strobes rise on the same edge, the output stays released and no read data appears.
- R8: If `addr` changes inside one window, only the address sampled on the window's last cycle is written. Addresses sampled earlier in that window keep their old contents.
- R9: `wr_n`=0 sampled with `sel_n`=1 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Data-in bus |
| rd_data | output | DATA_W | Data-out value, 0 when not driven |
| rd_en | output | 1 | Data-out drive enable (0 = high impedance) |
| pwr_down | output | 1 | Deselected power-down flag |

## Verification
The bench drives both output variants side by side. It opens windows that change data and address mid-window, then reads the location on the very next cycle. A design that committed the first sample of a window, or wrote every cycle of it, would show stale data or corrupt the earlier address. A design that read the array without the pending-word bypass would return the pre-write contents. Windows closed by the select rising, by both strobes rising together, and a write strobe pulsed while deselected catch a part that drives read data after a write or that stores outside the overlap.

// File: rtl/sepio_pkg.sv
package sepio_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sepio_decode.sv
module sepio_decode
  import sepio_pkg::*;
(
  input  logic sel_n,
  input  logic wr_n,
  output op_e  op
);
  always_comb begin
    if (sel_n)     op = OP_IDLE;
    else if (wr_n) op = OP_READ;
    else           op = OP_WRITE;
  end
endmodule

// File: rtl/sepio_wrbuf.sv
module sepio_wrbuf
  import sepio_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pend_vld,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data,
  output logic              commit
);
  // the held word goes to the array on the first cycle outside the window
  assign commit = pend_vld && (op != OP_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (op == OP_WRITE) begin
      pend_vld  <= 1'b1;
      pend_addr <= addr;
      pend_data <= wr_data;
    end else if (commit) begin
      pend_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/sepio_array.sv
module sepio_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sepio_outstage.sv
module sepio_outstage
  import sepio_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 4,
  parameter bit WR_THRU = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pend_vld,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [DATA_W-1:0] pend_data,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic              pwr_down
);
  op_e               op_q;
  logic              use_ram_q;
  logic [DATA_W-1:0] dsel_q;
  logic              drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OP_IDLE;
      pwr_down  <= 1'b1;
      use_ram_q <= 1'b0;
      dsel_q    <= '0;
    end else begin
      op_q     <= op;
      pwr_down <= (op == OP_IDLE);
      if (op == OP_WRITE) begin
        dsel_q    <= wr_data;
        use_ram_q <= 1'b0;
      end else begin
        dsel_q    <= pend_data;
        use_ram_q <= !(pend_vld && (pend_addr == addr));
      end
    end
  end

  generate
    if (WR_THRU) begin : g_thru
      assign drive = (op_q != OP_IDLE);
    end else begin : g_hiz
      assign drive = (op_q == OP_READ);
    end
  endgenerate

  assign rd_en   = drive;
  assign rd_data = drive ? (use_ram_q ? ram_q : dsel_q) : '0;
endmodule

// File: rtl/sepio_sram.sv
module sepio_sram
  import sepio_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 4,
  parameter bit WR_THRU = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic              pwr_down
);
  op_e               op;
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              commit;
  logic [DATA_W-1:0] ram_q;

  sepio_decode u_dec (
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .op    (op)
  );

  sepio_wrbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wrbuf (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .addr      (addr),
    .wr_data   (wr_data),
    .pend_vld  (pend_vld),
    .pend_addr (pend_addr),
    .pend_data (pend_data),
    .commit    (commit)
  );

  sepio_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (commit),
    .waddr (pend_addr),
    .wdata (pend_data),
    .raddr (addr),
    .rdata (ram_q)
  );

  sepio_outstage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_THRU(WR_THRU)) u_out (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .addr      (addr),
    .wr_data   (wr_data),
    .pend_vld  (pend_vld),
    .pend_addr (pend_addr),
    .pend_data (pend_data),
    .ram_q     (ram_q),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .pwr_down  (pwr_down)
  );
endmodule

// File: rtl/sepio_sram_chk.sv
module sepio_sram_chk #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 4,
  parameter bit WR_THRU = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_en,
  input logic              pwr_down
);
  // R5
  pdown_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pwr_down == $past(sel_n)));

  // R4
  pdown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> !rd_en);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == '0));

  // R3
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!sel_n && wr_n)) |-> rd_en);

  generate
    if (WR_THRU) begin : g_thru
      // R6
      thru_echo_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!sel_n && !wr_n)) |-> (rd_en && rd_data == $past(wr_data)));
    end else begin : g_hiz
      // R7
      hiz_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!sel_n && !wr_n)) |-> !rd_en);
    end
  endgenerate

  // addr is carried for probing only
  logic unused_ok;
  assign unused_ok = ^addr;
endmodule

bind sepio_sram sepio_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_THRU(WR_THRU)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_n    (sel_n),
  .wr_n     (wr_n),
  .addr     (addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .rd_en    (rd_en),
  .pwr_down (pwr_down)
);

// File: tb/sepio_sram_bench.sv
`timescale 1ns/1ps
module sepio_sram_bench;
  localparam int AW = 10;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b0, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dt, dh;
  logic          et, eh, pt, ph_o;

  int total = 0, bad = 0;
  string ph = "R1";

  always #2 clk = ~clk;

  sepio_sram #(.ADDR_W(AW), .DATA_W(DW), .WR_THRU(1'b1)) u_sepio_sram (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .addr(addr), .wr_data(wr_data),
    .rd_data(dt), .rd_en(et), .pwr_down(pt));

  sepio_sram #(.ADDR_W(AW), .DATA_W(DW), .WR_THRU(1'b0)) u_sepio_sram_hz (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .addr(addr), .wr_data(wr_data),
    .rd_data(dh), .rd_en(eh), .pwr_down(ph_o));

  // behavioural reference
  int    mm [int];
  bit    pv = 0;
  int    pa = 0, pd = 0;
  bit    armed = 0;
  int    mode = 0;        // 0 idle, 1 read, 2 write
  int    exp_val = 0;
  bit    known = 1;
  bit    exp_pd = 1;
  string tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      pv = 0; mode = 0; exp_pd = 1; exp_val = 0; known = 1; tag = "R1";
    end else begin
      int a;
      a = int'(addr);
      exp_pd = sel_n;
      if (sel_n) begin
        mode = 0; tag = "R4"; exp_val = 0; known = 1;
      end else if (wr_n) begin
        mode = 1; tag = "R3";
        if (pv && pa == a) begin exp_val = pd; known = 1; end
        else if (mm.exists(a)) begin exp_val = mm[a]; known = 1; end
        else known = 0;
      end else begin
        mode = 2; tag = "R6"; exp_val = int'(wr_data); known = 1;
      end
      if (!sel_n && !wr_n) begin
        pv = 1; pa = a; pd = int'(wr_data);
      end else if (pv) begin
        mm[pa] = pd; pv = 0;
      end
    end
    armed = 1;
  end

  task automatic chk(input bit ok, input string req, input string nm, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (phase %s) %s actual=%0h expected=%0h at %0t", req, ph, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      bit e_t, e_h;
      e_t = (mode != 0);
      e_h = (mode == 1);
      chk(pt == exp_pd, (mode == 0 && tag == "R1") ? "R1" : "R5", "thru pwr_down", int'(pt), int'(exp_pd));
      chk(ph_o == exp_pd, (tag == "R1") ? "R1" : "R5", "hiz pwr_down", int'(ph_o), int'(exp_pd));
      chk(et == e_t, tag, "thru rd_en", int'(et), int'(e_t));
      chk(eh == e_h, (mode == 2) ? "R7" : tag, "hiz rd_en", int'(eh), int'(e_h));
      if (known) begin
        chk(int'(dt) == exp_val, tag, "thru rd_data", int'(dt), exp_val);
        chk(int'(dh) == ((mode == 1) ? exp_val : 0), (mode == 2) ? "R7" : tag,
            "hiz rd_data", int'(dh), (mode == 1) ? exp_val : 0);
      end
    end
  end

  task automatic cyc(input bit s, input bit w, input int a, input int d);
    @(negedge clk);
    #1;
    sel_n = s; wr_n = w; addr = AW'(a); wr_data = DW'(d);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog (phase %s) actual=timeout expected=finish", ph);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset with the part selected
    repeat (4) cyc(0, 1, 3, 0);
    @(negedge clk); #1; rst = 0;
    ph = "R4";
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    // R2: window closed by write strobe, then by select
    ph = "R2";
    cyc(0, 0, 5, 3); cyc(0, 0, 5, 9); cyc(0, 1, 5, 0); cyc(0, 1, 5, 0);
    cyc(0, 0, 6, 4); cyc(1, 0, 6, 4); cyc(0, 1, 6, 0); cyc(1, 1, 6, 0);
    // R7: both strobes rise together
    ph = "R7";
    cyc(0, 0, 7, 10); cyc(1, 1, 7, 0); cyc(0, 1, 7, 0); cyc(0, 1, 7, 0);
    // R8: address moves inside a window
    ph = "R8";
    cyc(0, 0, 10, 7); cyc(0, 1, 10, 0);
    cyc(0, 0, 10, 1); cyc(0, 0, 11, 2); cyc(0, 1, 10, 0); cyc(0, 1, 11, 0);
    // R9: write strobe while deselected
    ph = "R9";
    cyc(1, 0, 5, 15); cyc(1, 0, 5, 15); cyc(1, 1, 5, 0); cyc(0, 1, 5, 0);
    // R3: bulk write then read back in reverse, including top address
    ph = "R3";
    for (int i = 0; i < 64; i++) begin
      cyc(0, 0, (i * 37 + 100) % (1 << AW), i ^ 5);
      cyc(0, 1, (i * 11) % (1 << AW), 0);
    end
    cyc(0, 0, (1 << AW) - 1, 12); cyc(1, 1, 0, 0);
    for (int i = 63; i >= 0; i--) cyc(0, 1, (i * 37 + 100) % (1 << AW), 0);
    cyc(0, 1, (1 << AW) - 1, 0);
    // R5 and R6: select toggling with back-to-back write/read
    ph = "R5";
    for (int i = 0; i < 16; i++) begin
      cyc(i % 3 == 0, i % 2 == 0, i, i);
    end
    ph = "R6";
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 200 + i, 15 - i);
      cyc(0, 1, 200 + i, 0);
    end
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    @(negedge clk); #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule